// File: doc/BRIEF.md
# Banked UART Register Decoder

This block is the byte-wide register front end of a single 16550-style UART channel. A host presents a 4-bit register offset together with a read strobe, a write strobe and a write byte. The block returns the selected byte, keeps the channel's configuration registers, and signals the transmit and receive FIFOs outside it. Serial shifting, baud generation and interrupt prioritisation are handled by logic around it. Line status, modem status, interrupt status and the receive FIFO head byte arrive on input ports.

Bit 7 of the line control register switches offsets 0 to 2 between two banks. When the bit is set, those offsets reach the divisor low byte, divisor high byte and fractional divisor. When it is clear, they reach the holding registers, the interrupt enable register and the interrupt status / FIFO control pair. At some offsets a read and a write reach different functions. A write-only turnaround delay register for RS-485 direction control shares offset 6 with modem status. Writes to it take effect only while bit 4 of an enhanced feature control input is set. An extra feature control register sits at offset 8.

Read data is combinational and valid in the same cycle as the read strobe. Register writes take effect at the rising clock edge that ends the write strobe cycle. The FIFO push and pop strobes are combinational and last one cycle for each strobed cycle.

Top module: `uart_regbank`

## Requirements
- R1: While reset is asserted and after it is released, every stored register reads zero, except the divisor, which holds 1: low byte 0x01, high byte 0x00.
- R2: With LCR bit 7 clear, a read at offset 0 returns the receive FIFO head byte and raises rx_pop in that cycle. A write at offset 0 raises tx_push in that cycle with tx_data equal to the written byte. Neither strobe rises in any other case.
- R3: With LCR bit 7 set, offsets 0, 1 and 2 read and write the divisor low byte, divisor high byte and fractional divisor. A read at offset 0 in this bank never raises rx_pop, and a write there never raises tx_push.
- R4: With LCR bit 7 clear, offset 1 is the interrupt enable register, readable and writable.
- R5: With LCR bit 7 clear, a read at offset 2 returns the interrupt status input, and a write at offset 2 loads the FIFO control register, which no read can return.
- R6: Offset 3 is the line control register, readable and writable whatever the value of its bit 7.
- R7: Offset 4 is the modem control register, readable and writable. A read at offset 5 returns the line status input, and a write at offset 5 changes no register.
- R8: A read at offset 6 returns the modem status input. A write at offset 6 loads the turnaround delay register only when bit 4 of the enhanced feature control input is 1; otherwise the register keeps its value.
- R9: Offset 7 is a scratch register and offset 8 is the feature control register, both readable and writable.
- R10: Reads at offsets 9 to 15 return zero, and writes there change no register.
- R11: rd_data is zero in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | 4 | Register offset |
| rd_stb | input | 1 | Read strobe, one access per cycle high |
| wr_stb | input | 1 | Write strobe, one access per cycle high |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the strobe cycle |
| enh_ctrl | input | 8 | Enhanced feature control value; bit 4 unlocks delay writes |
| rx_head | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Pop request to the receive FIFO |
| tx_data | output | 8 | Byte pushed into the transmit FIFO |
| tx_push | output | 1 | Push request to the transmit FIFO |
| irq_stat | input | 8 | Interrupt status byte |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| div_lo | output | 8 | Divisor low byte |
| div_hi | output | 8 | Divisor high byte |
| div_frac | output | 8 | Fractional divisor |
| int_en | output | 8 | Interrupt enable register |
| fifo_ctl | output | 8 | FIFO control register |
| line_ctl | output | 8 | Line control register |
| modem_ctl | output | 8 | Modem control register |
| feat_ctl | output | 8 | Feature control register |
| turn_dly | output | 8 | RS-485 turnaround delay register |

## Verification
The bench builds the block with its default parameters: a 4-bit offset, the bank-select bit at position 7, the delay unlock at bit 4 and a reset divisor of 1. With this offset width, every one of the 16 offsets is reachable, including the unused range 9 to 15. Random writes at offset 3 flip the bank-select bit many times, so both banks at offsets 0 to 2 are exercised, including reads at offset 0 that must not pop. The unlock bit on enh_ctrl is randomised for every access, so gated and ungated delay writes are both covered.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam int unsigned UREG_W = 8;

  // Register offsets; values are fixed by the access map.
  localparam int unsigned OFS_HOLD  = 0;
  localparam int unsigned OFS_IEN   = 1;
  localparam int unsigned OFS_STAT  = 2;
  localparam int unsigned OFS_LCTL  = 3;
  localparam int unsigned OFS_MCTL  = 4;
  localparam int unsigned OFS_LSTAT = 5;
  localparam int unsigned OFS_MSTAT = 6;
  localparam int unsigned OFS_SCR   = 7;
  localparam int unsigned OFS_FEAT  = 8;

  // One-hot decoded target of the current offset (independent of strobes).
  typedef struct packed {
    logic hold;     // bank 0, offset 0: receive pop / transmit push
    logic dv_lo;    // bank 1, offset 0
    logic dv_hi;    // bank 1, offset 1
    logic dv_fr;    // bank 1, offset 2
    logic ien;      // bank 0, offset 1
    logic stat_fc;  // bank 0, offset 2: status read / FIFO control write
    logic lctl;
    logic mctl;
    logic lstat;
    logic mstat_dly;
    logic scr;
    logic feat;
  } reg_sel_t;

  typedef struct packed {
    logic [UREG_W-1:0] dv_lo;
    logic [UREG_W-1:0] dv_hi;
    logic [UREG_W-1:0] dv_fr;
    logic [UREG_W-1:0] ien;
    logic [UREG_W-1:0] fctl;
    logic [UREG_W-1:0] lctl;
    logic [UREG_W-1:0] mctl;
    logic [UREG_W-1:0] dly;
    logic [UREG_W-1:0] scr;
    logic [UREG_W-1:0] feat;
  } reg_file_t;

endpackage

// File: rtl/uart_regbank_rst_sync.sv
module uart_regbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_div,
  output reg_sel_t          sel
);

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(OFS_HOLD)) begin
      if (bank_div) sel.dv_lo = 1'b1;
      else          sel.hold  = 1'b1;
    end
    if (addr == ADDR_W'(OFS_IEN)) begin
      if (bank_div) sel.dv_hi = 1'b1;
      else          sel.ien   = 1'b1;
    end
    if (addr == ADDR_W'(OFS_STAT)) begin
      if (bank_div) sel.dv_fr   = 1'b1;
      else          sel.stat_fc = 1'b1;
    end
    if (addr == ADDR_W'(OFS_LCTL))  sel.lctl      = 1'b1;
    if (addr == ADDR_W'(OFS_MCTL))  sel.mctl      = 1'b1;
    if (addr == ADDR_W'(OFS_LSTAT)) sel.lstat     = 1'b1;
    if (addr == ADDR_W'(OFS_MSTAT)) sel.mstat_dly = 1'b1;
    if (addr == ADDR_W'(OFS_SCR))   sel.scr       = 1'b1;
    if (addr == ADDR_W'(OFS_FEAT))  sel.feat      = 1'b1;
  end

endmodule

// File: rtl/uart_regbank_store.sv
module uart_regbank_store
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DIV_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [UREG_W-1:0] wr_data,
  input  reg_sel_t          sel,
  input  logic              dly_unlock,
  output reg_file_t         q
);

  localparam logic [2*UREG_W-1:0] DIV_RST_V = (2*UREG_W)'(DIV_RST);

  reg_file_t d;
  logic      wr_en;

  assign wr_en = wr_stb;

  always_comb begin
    d = q;
    if (sel.dv_lo)                  d.dv_lo = wr_data;
    if (sel.dv_hi)                  d.dv_hi = wr_data;
    if (sel.dv_fr)                  d.dv_fr = wr_data;
    if (sel.ien)                    d.ien   = wr_data;
    if (sel.stat_fc)                d.fctl  = wr_data;
    if (sel.lctl)                   d.lctl  = wr_data;
    if (sel.mctl)                   d.mctl  = wr_data;
    if (sel.mstat_dly && dly_unlock) d.dly  = wr_data;
    if (sel.scr)                    d.scr   = wr_data;
    if (sel.feat)                   d.feat  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '{dv_lo: DIV_RST_V[UREG_W-1:0], dv_hi: DIV_RST_V[2*UREG_W-1:UREG_W], default: '0};
    end else if (wr_en) begin
      q <= d;
    end
  end

  // Read-side selections carry no storage here.
  logic unused_sel;
  assign unused_sel = sel.hold ^ sel.lstat;

  // R8: a delay write without the unlock bit leaves the register alone.
  a_r8_dly_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_unlock |=> $stable(q.dly));

  // R7: writes to the line status offset touch nothing.
  a_r7_lstat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sel.lstat) |=> $stable(q));

  // R6: line control takes the written byte in either bank.
  a_r6_lctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sel.lctl) |=> (q.lctl == $past(wr_data)));

endmodule

// File: rtl/uart_regbank_rdmux.sv
module uart_regbank_rdmux
  import uart_regbank_pkg::*;
(
  input  logic              rd_stb,
  input  reg_sel_t          sel,
  input  reg_file_t         q,
  input  logic [UREG_W-1:0] rx_head,
  input  logic [UREG_W-1:0] irq_stat,
  input  logic [UREG_W-1:0] line_stat,
  input  logic [UREG_W-1:0] modem_stat,
  output logic [UREG_W-1:0] rd_data
);

  logic [UREG_W-1:0] mux;

  always_comb begin
    mux = '0;
    if (sel.hold)      mux = mux | rx_head;
    if (sel.dv_lo)     mux = mux | q.dv_lo;
    if (sel.dv_hi)     mux = mux | q.dv_hi;
    if (sel.dv_fr)     mux = mux | q.dv_fr;
    if (sel.ien)       mux = mux | q.ien;
    if (sel.stat_fc)   mux = mux | irq_stat;
    if (sel.lctl)      mux = mux | q.lctl;
    if (sel.mctl)      mux = mux | q.mctl;
    if (sel.lstat)     mux = mux | line_stat;
    if (sel.mstat_dly) mux = mux | modem_stat;
    if (sel.scr)       mux = mux | q.scr;
    if (sel.feat)      mux = mux | q.feat;
    rd_data = rd_stb ? mux : '0;
  end

  // Write-only registers are never returned.
  logic unused_wo;
  assign unused_wo = ^{q.fctl, q.dly};

  always_comb begin
    a_r5_sel_onehot: assert ($onehot0(sel));
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned BANK_BIT   = 7,
  parameter int unsigned UNLOCK_BIT = 4,
  parameter int unsigned DIV_RST    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [7:0]        enh_ctrl,
  input  logic [7:0]        rx_head,
  output logic              rx_pop,
  output logic [7:0]        tx_data,
  output logic              tx_push,
  input  logic [7:0]        irq_stat,
  input  logic [7:0]        line_stat,
  input  logic [7:0]        modem_stat,
  output logic [7:0]        div_lo,
  output logic [7:0]        div_hi,
  output logic [7:0]        div_frac,
  output logic [7:0]        int_en,
  output logic [7:0]        fifo_ctl,
  output logic [7:0]        line_ctl,
  output logic [7:0]        modem_ctl,
  output logic [7:0]        feat_ctl,
  output logic [7:0]        turn_dly
);

  logic      srst_n;
  reg_sel_t  sel;
  reg_file_t q;
  logic      bank_div;
  logic      dly_unlock;

  uart_regbank_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  assign bank_div   = q.lctl[BANK_BIT];
  assign dly_unlock = enh_ctrl[UNLOCK_BIT];

  uart_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (reg_addr),
    .bank_div(bank_div),
    .sel     (sel)
  );

  uart_regbank_store #(.DIV_RST(DIV_RST)) u_store (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .sel       (sel),
    .dly_unlock(dly_unlock),
    .q         (q)
  );

  uart_regbank_rdmux u_rd (
    .rd_stb    (rd_stb),
    .sel       (sel),
    .q         (q),
    .rx_head   (rx_head),
    .irq_stat  (irq_stat),
    .line_stat (line_stat),
    .modem_stat(modem_stat),
    .rd_data   (rd_data)
  );

  assign rx_pop  = rd_stb & sel.hold;
  assign tx_push = wr_stb & sel.hold;
  assign tx_data = wr_data;

  assign div_lo    = q.dv_lo;
  assign div_hi    = q.dv_hi;
  assign div_frac  = q.dv_fr;
  assign int_en    = q.ien;
  assign fifo_ctl  = q.fctl;
  assign line_ctl  = q.lctl;
  assign modem_ctl = q.mctl;
  assign feat_ctl  = q.feat;
  assign turn_dly  = q.dly;

  logic unused_enh;
  assign unused_enh = ^{enh_ctrl[7:UNLOCK_BIT+1], enh_ctrl[UNLOCK_BIT-1:0]};

  // R2, R3: a pop needs a read strobe in the holding bank.
  a_r2_pop_in_hold_bank: assert property (@(posedge clk) disable iff (!srst_n)
    rx_pop |-> (rd_stb && !line_ctl[BANK_BIT]));

  // R3: a push never happens while the divisor bank is selected.
  a_r3_no_push_in_div_bank: assert property (@(posedge clk) disable iff (!srst_n)
    line_ctl[BANK_BIT] |-> !tx_push);

  // R11: idle read bus.
  a_r11_idle_rd_zero: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_stb |-> (rd_data == 8'h00));

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       rd_stb, wr_stb;
  logic [7:0] wr_data, rd_data, enh_ctrl, rx_head, tx_data;
  logic       rx_pop, tx_push;
  logic [7:0] irq_stat, line_stat, modem_stat;
  logic [7:0] div_lo, div_hi, div_frac, int_en, fifo_ctl, line_ctl, modem_ctl, feat_ctl, turn_dly;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected register state
  logic [7:0] m_lo, m_hi, m_fr, m_ien, m_fc, m_lc, m_mc, m_dly, m_scr, m_feat;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .enh_ctrl(enh_ctrl), .rx_head(rx_head),
    .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push), .irq_stat(irq_stat),
    .line_stat(line_stat), .modem_stat(modem_stat), .div_lo(div_lo), .div_hi(div_hi),
    .div_frac(div_frac), .int_en(int_en), .fifo_ctl(fifo_ctl), .line_ctl(line_ctl),
    .modem_ctl(modem_ctl), .feat_ctl(feat_ctl), .turn_dly(turn_dly)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a, input logic r);
    logic bank;
    bank = m_lc[7];
    if (!r) return 8'h00;                          // R11
    case (a)
      4'd0: return bank ? m_lo : rx_head;          // R2 / R3
      4'd1: return bank ? m_hi : m_ien;            // R3 / R4
      4'd2: return bank ? m_fr : irq_stat;         // R3 / R5
      4'd3: return m_lc;                           // R6
      4'd4: return m_mc;                           // R7
      4'd5: return line_stat;                      // R7
      4'd6: return modem_stat;                     // R8
      4'd7: return m_scr;                          // R9
      4'd8: return m_feat;                         // R9
      default: return 8'h00;                       // R10
    endcase
  endfunction

  function automatic string read_tag(input logic [3:0] a, input logic r);
    if (!r) return "R11 idle read";
    if (a <= 4'd2 && m_lc[7]) return "R3 divisor read";
    case (a)
      4'd0: return "R2 receive read";
      4'd1: return "R4 int enable read";
      4'd2: return "R5 status read";
      4'd3: return "R6 line ctl read";
      4'd4, 4'd5: return "R7 modem ctl/line stat read";
      4'd6: return "R8 modem stat read";
      4'd7, 4'd8: return "R9 scratch/feature read";
      default: return "R10 unused read";
    endcase
  endfunction

  task automatic check_regs(input string tag);
    check({tag, " R3 div_lo"},   div_lo,    m_lo);
    check({tag, " R3 div_hi"},   div_hi,    m_hi);
    check({tag, " R3 div_frac"}, div_frac,  m_fr);
    check({tag, " R4 int_en"},   int_en,    m_ien);
    check({tag, " R5 fifo_ctl"}, fifo_ctl,  m_fc);
    check({tag, " R6 line_ctl"}, line_ctl,  m_lc);
    check({tag, " R7 modem_ctl"},modem_ctl, m_mc);
    check({tag, " R8 turn_dly"}, turn_dly,  m_dly);
    check({tag, " R9 feat_ctl"}, feat_ctl,  m_feat);
  endtask

  // One access: drive at negedge, check before posedge, update model at posedge.
  task automatic step(input logic [3:0] a, input logic r, input logic w,
                      input logic [7:0] wd, input logic [7:0] enh);
    logic bank;
    reg_addr = a; rd_stb = r; wr_stb = w; wr_data = wd; enh_ctrl = enh;
    rx_head = 8'($urandom); irq_stat = 8'($urandom);
    line_stat = 8'($urandom); modem_stat = 8'($urandom);
    #2;
    bank = m_lc[7];
    check(read_tag(a, r), rd_data, exp_read(a, r));
    check("R2/R3 rx_pop", {7'd0, rx_pop}, {7'd0, r && a == 4'd0 && !bank});
    check("R2/R3 tx_push", {7'd0, tx_push}, {7'd0, w && a == 4'd0 && !bank});
    if (tx_push) check("R2 tx_data", tx_data, wd);
    @(posedge clk);
    if (w) begin
      case (a)
        4'd0: if (bank) m_lo = wd;
        4'd1: if (bank) m_hi = wd; else m_ien = wd;
        4'd2: if (bank) m_fr = wd; else m_fc = wd;
        4'd3: m_lc = wd;
        4'd4: m_mc = wd;
        4'd6: if (enh[4]) m_dly = wd;
        4'd7: m_scr = wd;
        4'd8: m_feat = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    #2;
    check_regs("post-write");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0;
    reg_addr = '0; rd_stb = 0; wr_stb = 0; wr_data = '0; enh_ctrl = '0;
    rx_head = '0; irq_stat = '0; line_stat = '0; modem_stat = '0;
    m_lo = 8'h01; m_hi = 0; m_fr = 0; m_ien = 0; m_fc = 0; m_lc = 0;
    m_mc = 0; m_dly = 0; m_scr = 0; m_feat = 0;
    repeat (3) @(posedge clk);
    #2;
    check_regs("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check_regs("R1 after reset");
    check("R1 scratch reset", rd_data, 8'h00);
    @(negedge clk);
    step(4'd7, 1, 0, 8'h00, 8'h00);               // R1 scratch reads zero

    // Directed corner cases
    step(4'd0, 1, 0, 8'h00, 8'h00);               // R2 pop in holding bank
    step(4'd0, 0, 1, 8'hA5, 8'h00);               // R2 push
    step(4'd3, 0, 1, 8'h83, 8'h00);               // R6 select divisor bank
    step(4'd0, 1, 0, 8'h00, 8'h00);               // R3 read divisor, no pop
    step(4'd0, 0, 1, 8'h34, 8'h00);               // R3 divisor low, no push
    step(4'd1, 0, 1, 8'h12, 8'h00);               // R3
    step(4'd2, 0, 1, 8'h07, 8'h00);               // R3 fractional
    step(4'd3, 1, 0, 8'h00, 8'h00);               // R6 readable in divisor bank
    step(4'd3, 0, 1, 8'h03, 8'h00);               // R6 back to holding bank
    step(4'd2, 1, 1, 8'hC7, 8'h00);               // R5 FIFO control write, status read
    step(4'd1, 0, 1, 8'h0F, 8'h00);               // R4
    step(4'd1, 1, 0, 8'h00, 8'h00);               // R4
    step(4'd5, 0, 1, 8'hFF, 8'h00);               // R7 read-only offset
    step(4'd6, 0, 1, 8'h55, 8'h00);               // R8 locked
    step(4'd6, 0, 1, 8'h66, 8'h10);               // R8 unlocked
    step(4'd6, 0, 1, 8'h77, 8'hEF);               // R8 other bits set, still locked
    step(4'd8, 0, 1, 8'h9C, 8'h00);               // R9
    step(4'd12, 1, 1, 8'hEE, 8'hFF);              // R10
    step(4'd15, 1, 0, 8'h00, 8'h00);              // R10

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      a = ($urandom % 4 == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
      step(a, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    rd_stb = 0; wr_stb = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule